// File: doc/BRIEF.md
# Tricolor Matrix Shade Scanner

This block scans a common-cathode dot matrix whose dots each carry one red and one green emitter. Each colour has several stored on/off bit planes. The scanner shows every plane for one full pass over all common lines, then moves to the next plane. A dot therefore lights for a share of each colour period that equals the number of ones held in its planes. Lighting both emitters gives orange, and lighting neither leaves the dot blank. With four planes per colour there are 25/50/75/100 % levels of red, green and orange, plus blank.

A host loads plane bytes through a single write port. Each write selects a colour, a plane, a line and a byte of column bits. Writes land in a shadow copy. The shadow copy moves into the displayed copy only when the last plane finishes, so a half-updated picture never appears. For each line slot, the row bytes are registered during a one-clock blank, and the line select is driven only after that. Because of this, a change of line never shows the data of the neighbouring line.

Top module: `led_shade_scanner`

## Requirements
- R1: While reset is asserted (rst_n low), com_sel, red_row and green_row are all zero.
- R2: At most one bit of com_sel is high in any cycle.
- R3: Each line slot begins with exactly one clock in which com_sel is zero. Two different lines are never selected in consecutive clocks.
- R4: While the same line stays selected, red_row and green_row do not change.
- R5: Bit k of com_sel selects line k. Lines are shown in the order 0, 1, ..., LINES-1 and then wrap to 0. Each slot lasts DWELL_CLKS clocks, and the line is selected for DWELL_CLKS-1 of them.
- R6: The plane index advances only after the last line's slot. It steps through 0, 1, ..., PLANES_PER_COLOR-1 and then wraps, so one colour period lasts PLANES_PER_COLOR*LINES*DWELL_CLKS clocks.
- R7: Over one colour period, the red (green) emitter of a dot is lit for n*(DWELL_CLKS-1) clocks, where n is the number of planes of that colour holding a one for the dot. Which planes hold the ones has no effect.
- R8: Red and green are driven independently. A dot with ones in both colours lights both emitters in the same clocks, which gives orange.
- R9: A write changes only the shadow copy. The displayed picture does not change until the colour period ends, and the new contents appear from the first slot of the next period.
- R10: A write with wr_en high stores wr_data in the word for colour wr_green (0 = red, 1 = green), plane wr_plane and line wr_line. Bit b of that byte drives bit b of red_row or green_row, and no other word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store one plane byte this clock |
| wr_green | input | 1 | Colour of the write: 0 red, 1 green |
| wr_plane | input | PLANE_W | Plane index of the write |
| wr_line | input | LINE_W | Line index of the write |
| wr_data | input | COLS | Column bits for that plane and line |
| com_sel | output | LINES | One-hot common-line select, all zero during blanks |
| red_row | output | COLS | Red column data for the selected line |
| green_row | output | COLS | Green column data for the selected line |

## Verification
The bench builds the scanner with four planes per colour, eight lines, eight columns and a four-clock slot, so one colour period lasts 128 clocks. That setting reaches all five levels per colour (zero to four ones), so every one of the 13 shades can be told apart by on-time in steps of three clocks. It also makes permuted patterns such as 0110 against 1001 a real test of count-only shading. Two settle periods after each batch of writes align every on-time measurement to a period boundary, and that alignment lets the bench watch the shadow-to-display swap happen at one known clock.

// File: rtl/led_shade_pkg.sv
package led_shade_pkg;

   typedef enum logic {
      CH_RED   = 1'b0,
      CH_GREEN = 1'b1
   } chan_e;

   // Flat word number of one plane byte: colour, then plane, then line.
   function automatic int word_at(input int chan, input int plane, input int line,
                                  input int planes, input int lines);
      return (chan * planes + plane) * lines + line;
   endfunction

endpackage

// File: rtl/led_scan_timer.sv
module led_scan_timer #(
   parameter int LINES  = 8,
   parameter int PLANES = 4,
   parameter int DWELL  = 4,
   localparam int LW = $clog2(LINES),
   localparam int PW = $clog2(PLANES)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [LW-1:0] line_idx,
   output logic [PW-1:0] plane_idx,
   output logic          slot_start,
   output logic          period_end
);
   localparam int DW = $clog2(DWELL);
   localparam logic [DW-1:0] DWELL_LAST = DW'(DWELL - 1);
   localparam logic [LW-1:0] LINE_LAST  = LW'(LINES - 1);
   localparam logic [PW-1:0] PLANE_LAST = PW'(PLANES - 1);

   logic [DW-1:0] dwell_q;
   logic [LW-1:0] line_q;
   logic [PW-1:0] plane_q;
   logic dwell_last, line_last, plane_last;

   assign dwell_last = (dwell_q == DWELL_LAST);
   assign line_last  = (line_q == LINE_LAST);
   assign plane_last = (plane_q == PLANE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dwell_q <= '0;
         line_q  <= '0;
         plane_q <= '0;
      end else if (dwell_last) begin
         dwell_q <= '0;
         if (line_last) begin
            line_q  <= '0;
            plane_q <= plane_last ? '0 : plane_q + 1'b1;
         end else begin
            line_q <= line_q + 1'b1;
         end
      end else begin
         dwell_q <= dwell_q + 1'b1;
      end
   end

   assign line_idx   = line_q;
   assign plane_idx  = plane_q;
   assign slot_start = (dwell_q == '0);
   assign period_end = dwell_last && line_last && plane_last;

   AST_LINE_AFTER_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
      (line_q != $past(line_q)) |-> ($past(dwell_q) == DWELL_LAST)); // R5

   AST_PLANE_AFTER_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      (plane_q != $past(plane_q)) |-> ($past(line_q) == LINE_LAST && line_q == '0)); // R6

endmodule

// File: rtl/led_plane_store.sv
module led_plane_store #(
   parameter int LINES  = 8,
   parameter int PLANES = 4,
   parameter int DATA_W = 8,
   localparam int LW = $clog2(LINES),
   localparam int PW = $clog2(PLANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_chan,
   input  logic [PW-1:0]     wr_plane,
   input  logic [LW-1:0]     wr_line,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              swap,
   input  logic [PW-1:0]     rd_plane,
   input  logic [LW-1:0]     rd_line,
   output logic [DATA_W-1:0] rd_red,
   output logic [DATA_W-1:0] rd_green
);
   import led_shade_pkg::*;

   localparam int WORDS = 2 * PLANES * LINES;
   localparam int IW    = $clog2(WORDS);

   logic [WORDS-1:0][DATA_W-1:0] shadow_q;
   logic [WORDS-1:0][DATA_W-1:0] disp_q;
   logic [IW-1:0] wr_word, rd_word_r, rd_word_g;

   assign wr_word   = IW'(word_at(int'(wr_chan), int'(wr_plane), int'(wr_line), PLANES, LINES));
   assign rd_word_r = IW'(word_at(int'(CH_RED), int'(rd_plane), int'(rd_line), PLANES, LINES));
   assign rd_word_g = IW'(word_at(int'(CH_GREEN), int'(rd_plane), int'(rd_line), PLANES, LINES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (wr_en) begin
         shadow_q[wr_word] <= wr_data;
      end
   end

   // A write in the swap clock reaches the display one period later.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_q <= '0;
      end else if (swap) begin
         disp_q <= shadow_q;
      end
   end

   assign rd_red   = disp_q[rd_word_r];
   assign rd_green = disp_q[rd_word_g];

   AST_DISPLAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(swap) |-> $stable(disp_q)); // R9

endmodule

// File: rtl/led_shade_scanner.sv
module led_shade_scanner #(
   parameter int LINES            = 8,
   parameter int COLS             = 8,
   parameter int PLANES_PER_COLOR = 4,
   parameter int DWELL_CLKS       = 4,
   localparam int LINE_W  = $clog2(LINES),
   localparam int PLANE_W = $clog2(PLANES_PER_COLOR)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_green,
   input  logic [PLANE_W-1:0] wr_plane,
   input  logic [LINE_W-1:0]  wr_line,
   input  logic [COLS-1:0]    wr_data,
   output logic [LINES-1:0]   com_sel,
   output logic [COLS-1:0]    red_row,
   output logic [COLS-1:0]    green_row
);
   if (!(PLANES_PER_COLOR == 2 || PLANES_PER_COLOR == 4)) begin : g_bad_planes
      $error("PLANES_PER_COLOR must be 2 or 4");
   end
   if (DWELL_CLKS < 2) begin : g_bad_dwell
      $error("DWELL_CLKS must leave at least one lit clock after the blank");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end

   logic [LINE_W-1:0]  line_idx;
   logic [PLANE_W-1:0] plane_idx;
   logic               slot_start, period_end;
   logic [COLS-1:0]    rd_red, rd_green;
   logic [LINES-1:0]   line_hot;
   logic [LINES-1:0]   sel_q;
   logic [COLS-1:0]    red_q, green_q;

   led_scan_timer #(.LINES(LINES), .PLANES(PLANES_PER_COLOR), .DWELL(DWELL_CLKS)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_idx   (line_idx),
      .plane_idx  (plane_idx),
      .slot_start (slot_start),
      .period_end (period_end)
   );

   led_plane_store #(.LINES(LINES), .PLANES(PLANES_PER_COLOR), .DATA_W(COLS)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_chan  (wr_green),
      .wr_plane (wr_plane),
      .wr_line  (wr_line),
      .wr_data  (wr_data),
      .swap     (period_end),
      .rd_plane (plane_idx),
      .rd_line  (line_idx),
      .rd_red   (rd_red),
      .rd_green (rd_green)
   );

   for (genvar i = 0; i < LINES; i++) begin : g_line_dec
      assign line_hot[i] = (line_idx == LINE_W'(i));
   end

   // Row bytes are latched in the blank clock that opens each slot.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         red_q   <= '0;
         green_q <= '0;
      end else begin
         sel_q   <= slot_start ? '0 : line_hot;
         red_q   <= rd_red;
         green_q <= rd_green;
      end
   end

   assign com_sel   = sel_q;
   assign red_row   = red_q;
   assign green_row = green_q;

   AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_q)); // R2

   AST_BLANK_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q != '0 && $past(sel_q) != '0) |-> (sel_q == $past(sel_q))); // R3

   AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q != '0 && $past(sel_q) != '0) |-> ($stable(red_q) && $stable(green_q))); // R4

endmodule

// File: tb/led_shade_scanner_tb.sv
module led_shade_scanner_tb;
   localparam int P      = 4;
   localparam int D      = 4;
   localparam int L      = 8;
   localparam int C      = 8;
   localparam int PERIOD = P * L * D;
   localparam int SHOW   = D - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic wr_green = 1'b0;
   logic [1:0] wr_plane = '0;
   logic [2:0] wr_line = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] com_sel, red_row, green_row;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;
   logic [7:0] model [2][P][L];

   led_shade_scanner #(.LINES(L), .COLS(C), .PLANES_PER_COLOR(P), .DWELL_CLKS(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_green(wr_green),
      .wr_plane(wr_plane), .wr_line(wr_line), .wr_data(wr_data),
      .com_sel(com_sel), .red_row(red_row), .green_row(green_row)
   );

   always #10 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) cyc <= 0;
      else cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic wr(input int chan, input int plane, input int line, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_green = chan[0]; wr_plane = 2'(plane); wr_line = 3'(line); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model[chan][plane][line] = d;
   endtask

   // Stop at the first sample of a colour period (cyc mod PERIOD == 1).
   task automatic align();
      @(negedge clk);
      while (cyc % PERIOD != 1) @(negedge clk);
   endtask

   task automatic settle();
      align();
      align();
   endtask

   task automatic measure_all(input string tag);
      int cnt [2][L][C];
      for (int c = 0; c < 2; c++)
         for (int l = 0; l < L; l++)
            for (int b = 0; b < C; b++) cnt[c][l][b] = 0;
      settle();
      repeat (PERIOD) begin
         for (int l = 0; l < L; l++)
            if (com_sel[l])
               for (int b = 0; b < C; b++) begin
                  if (red_row[b])   cnt[0][l][b]++;
                  if (green_row[b]) cnt[1][l][b]++;
               end
         @(negedge clk);
      end
      for (int c = 0; c < 2; c++)
         for (int l = 0; l < L; l++)
            for (int b = 0; b < C; b++) begin
               int ones = 0;
               for (int p = 0; p < P; p++) ones += int'(model[c][p][l][b]);
               check(cnt[c][l][b] == ones * SHOW, tag,
                     $sformatf("on-time chan=%0d line=%0d col=%0d", c, l, b),
                     cnt[c][l][b], ones * SHOW);
            end
   endtask

   task automatic test_reset();
      @(negedge clk);
      check(com_sel == 8'h00, "R1", "com_sel in reset", int'(com_sel), 0);
      check(red_row == 8'h00, "R1", "red_row in reset", int'(red_row), 0);
      check(green_row == 8'h00, "R1", "green_row in reset", int'(green_row), 0);
      rst_n = 1'b1;
   endtask

   task automatic test_scan();
      int per_line [L];
      int blanks = 0;
      int last = -1;
      int first = -1;
      logic [7:0] prev_sel = '0, prev_r = '0, prev_g = '0;
      for (int l = 0; l < L; l++) per_line[l] = 0;
      settle();
      repeat (PERIOD) begin
         check($countones(com_sel) <= 1, "R2", "select not one-hot", $countones(com_sel), 1);
         if (com_sel == 8'h00) blanks++;
         else begin
            int cur = 0;
            for (int l = 0; l < L; l++) if (com_sel[l]) cur = l;
            per_line[cur]++;
            if (first < 0) first = cur;
            if (prev_sel != 8'h00) begin
               check(com_sel == prev_sel, "R3", "line change without blank",
                     int'(com_sel), int'(prev_sel));
               check(red_row == prev_r && green_row == prev_g, "R4", "row data moved in slot",
                     int'({red_row, green_row}), int'({prev_r, prev_g}));
            end
            if (cur != last && last >= 0)
               check(cur == (last + 1) % L, "R5", "line order", cur, (last + 1) % L);
            last = cur;
         end
         prev_sel = com_sel; prev_r = red_row; prev_g = green_row;
         @(negedge clk);
      end
      check(first == 0, "R5", "first line of period", first, 0);
      check(blanks == P * L, "R3", "blank clocks per period", blanks, P * L);
      for (int l = 0; l < L; l++)
         check(per_line[l] == P * SHOW, "R5", $sformatf("lit clocks line %0d", l),
               per_line[l], P * SHOW);
   endtask

   task automatic test_plane_order();
      logic [7:0] seen [$];
      for (int p = 0; p < P; p++) wr(0, p, 0, 8'(1 << p));
      settle();
      repeat (PERIOD) begin
         if (com_sel == 8'h01 && (seen.size() == 0 || seen[$] != red_row)) seen.push_back(red_row);
         @(negedge clk);
      end
      check(seen.size() == P, "R6", "distinct plane bytes on line 0", seen.size(), P);
      for (int p = 0; p < P && p < seen.size(); p++)
         check(seen[p] == 8'(1 << p), "R6", $sformatf("plane %0d byte", p),
               int'(seen[p]), 1 << p);
   endtask

   task automatic test_shades();
      // Line 2: column b holds b%5 ones in red and (4 - b%5) in green.
      for (int p = 0; p < P; p++) begin
         logic [7:0] r = '0, g = '0;
         for (int b = 0; b < C; b++) begin
            r[b] = (p < (b % 5));
            g[b] = (p < (4 - (b % 5)));
         end
         wr(0, p, 2, r);
         wr(1, p, 2, g);
      end
      measure_all("R7");
   endtask

   task automatic test_permute_orange();
      // Line 5, columns 0..3 take patterns 0110, 1001, 1100, 0011 (plane 3..0) in both colours.
      logic [3:0] pat [4] = '{4'b0110, 4'b1001, 4'b1100, 4'b0011};
      for (int p = 0; p < P; p++) begin
         logic [7:0] v = '0;
         for (int b = 0; b < 4; b++) v[b] = pat[b][p];
         wr(0, p, 5, v);
         wr(1, p, 5, v);
      end
      measure_all("R8");
   endtask

   task automatic test_no_tear();
      align();
      align();
      for (int p = 0; p < P; p++) wr(0, p, 0, 8'hF0);
      while (cyc % PERIOD != 1) begin
         if (com_sel == 8'h01)
            check((red_row & 8'hF0) == 8'h00, "R9", "new byte shown before period end",
                  int'(red_row), int'(red_row & 8'h0F));
         @(negedge clk);
      end
      measure_all("R9");
   endtask

   task automatic test_address();
      wr(1, 3, 7, 8'h81);
      wr(0, 1, 6, 8'h3C);
      measure_all("R10");
   endtask

   initial begin
      for (int c = 0; c < 2; c++)
         for (int p = 0; p < P; p++)
            for (int l = 0; l < L; l++) model[c][p][l] = 8'h00;
      test_reset();
      test_scan();
      test_plane_order();
      test_shades();
      test_permute_orange();
      test_no_tear();
      test_address();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog run incomplete actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule